// File: doc/BRIEF.md
# Shadowed-Configuration PWM Timer

This block produces one pulse-width-modulated output from a free-running count of the input clock. A small memory-mapped register set holds the counter, the period, the duty and a control word. Each register is a 32-bit word, and reads and writes use single-cycle strobes. One count is one clock cycle. In left-aligned continuous mode the counter steps from 0 to period-1 and wraps. The output is in its active phase while the count is below the duty value, and in its inactive phase for the rest of the period.

Software writes period, duty and the two polarity levels into staging copies. The active copies that drive the waveform change only on a wrap of the counter, so a cycle is never shortened, stretched or built from a mix of old and new settings. A lock bit in the control word blocks that transfer entirely. Software sets the lock, writes the new values at leisure, then clears the lock together with the new polarity. Period, duty and polarity then take effect at the same period start. While the timer is stopped nothing is in progress, so the staging copies pass straight through, and the next start uses the latest settings.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset, period and duty read 0, control reads 0x0000_0008, the counter reads 0 and `pwm_out` is low.
- R2: Word index `addr[3:2]` selects the register: 0 counter, 1 period, 2 duty, 3 control. Read data appears on `rdata` one cycle after the `rd_en` edge and holds until the next read. Period and duty store the low 16 bits of `wdata` and read back zero-extended. Control keeps only bits 0 to 6 and bit 8, and the other bits read as 0.
- R3: The counter register is read-only, and a write to index 0 leaves it unchanged. A read returns the count of the cycle in which the read is sampled.
- R4: The timer runs when control bit 0 (enable) is 1 and bits [2:1] (mode) are 01. While it runs, the count steps 0, 1, …, period-1 and wraps, and the output is in its active phase exactly while count < duty.
- R5: Control bit 3 gives the output level of the active phase, and bit 4 gives the level of the inactive phase (1 = high in both).
- R6: With the lock clear, a period or duty write made while the timer runs takes effect at the next wrap. A write on the very edge of a wrap waits for the following wrap.
- R7: While control bit 6 (lock) is set, the active period, duty and polarity stay unchanged across wraps.
- R8: After the lock is cleared, the staged period, duty and polarity all take effect at the same next wrap.
- R9: A duty greater than or equal to a nonzero period keeps the output in its active phase for the whole period.
- R10: A running timer with period 0 holds the output at its inactive level and the count at 0.
- R11: When the timer is not running, the counter is 0 and the output drives the active inactive-phase level. With the lock clear, the staged settings become active one cycle after they are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one count per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe, one word per cycle |
| addr | input | 4 | Byte address; bits [3:2] pick the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | PWM output |

## Verification
A control write that starts the timer lands on one edge. In the cycle after that edge the count is 0, so in the n-th cycle after it the output reflects count n mod period. The bench indexes every expected level by that n and samples at the falling edge. A register write is held in staging and reaches the waveform only in the cycle after the wrap edge (count = period-1). For this reason the lock and mid-period scenarios schedule each write at a known n and predict the first changed cycle from it, including a write placed on a wrap edge. A read strobe is sampled on one edge and its data is checked at the next falling edge. The counter value expected there is the n of the cycle in which the strobe was raised.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

    localparam int CTRL_W = 9;

    // word index = addr[3:2]
    localparam logic [1:0] WIDX_CNT  = 2'd0;
    localparam logic [1:0] WIDX_PER  = 2'd1;
    localparam logic [1:0] WIDX_DUTY = 2'd2;
    localparam logic [1:0] WIDX_CTRL = 2'd3;

    localparam logic [1:0] MODE_CONT = 2'b01;

    localparam logic [CTRL_W-1:0] CTRL_KEEP  = 9'h17F;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h008;

    typedef struct packed {
        logic       lp_en;    // bit 8
        logic       rsv;      // bit 7, reads 0
        logic       lock;     // bit 6
        logic       align;    // bit 5 (0 = left)
        logic       idle_hi;  // bit 4
        logic       act_hi;   // bit 3
        logic [1:0] mode;     // bits 2:1
        logic       en;       // bit 0
    } ctrl_t;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_shadow_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [CNT_W-1:0]  stg_per,
    output logic [CNT_W-1:0]  stg_duty,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata
);

    localparam int CNT_PAD  = DATA_W - CNT_W;
    localparam int CTRL_PAD = DATA_W - CTRL_W;

    typedef struct packed {
        logic [CNT_W-1:0]  per;
        logic [CNT_W-1:0]  duty;
        ctrl_t             ctrl;
        logic [DATA_W-1:0] rdata;
    } rf_state_t;

    rf_state_t s_d, s_q;
    logic [1:0] widx;

    logic unused_in;
    assign unused_in = ^{wdata[DATA_W-1:CNT_W], addr[1:0]};

    assign widx = addr[3:2];

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (widx)
                WIDX_PER:  s_d.per  = wdata[CNT_W-1:0];
                WIDX_DUTY: s_d.duty = wdata[CNT_W-1:0];
                WIDX_CTRL: s_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0] & CTRL_KEEP);
                default:   ;
            endcase
        end
        if (rd_en) begin
            case (widx)
                WIDX_CNT:  s_d.rdata = {{CNT_PAD{1'b0}}, live_cnt};
                WIDX_PER:  s_d.rdata = {{CNT_PAD{1'b0}}, s_q.per};
                WIDX_DUTY: s_d.rdata = {{CNT_PAD{1'b0}}, s_q.duty};
                default:   s_d.rdata = {{CTRL_PAD{1'b0}}, s_q.ctrl};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.per   <= '0;
            s_q.duty  <= '0;
            s_q.ctrl  <= ctrl_t'(CTRL_RESET);
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stg_per  = s_q.per;
    assign stg_duty = s_q.duty;
    assign ctrl     = s_q.ctrl;
    assign rdata    = s_q.rdata;

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       last;

    // period 0 counts as a wrap every cycle so staged values can still land
    assign last = (act_per == '0) || (s_q.cnt == act_per - 1'b1);
    assign wrap = running && last;

    always_comb begin
        s_d = s_q;
        if (!running || last) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;

endmodule

// File: rtl/pwm_commit.sv
module pwm_commit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             wrap,
    input  logic             lock,
    input  logic [CNT_W-1:0] stg_per,
    input  logic [CNT_W-1:0] stg_duty,
    input  logic             stg_act_hi,
    input  logic             stg_idle_hi,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_duty,
    output logic             act_hi,
    output logic             idle_hi
);

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic             act_hi;
        logic             idle_hi;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic       take;

    assign take = !lock && (wrap || !running);

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.per     = stg_per;
            s_d.duty    = stg_duty;
            s_d.act_hi  = stg_act_hi;
            s_d.idle_hi = stg_idle_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.per     <= '0;
            s_q.duty    <= '0;
            s_q.act_hi  <= 1'b1;
            s_q.idle_hi <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_per  = s_q.per;
    assign act_duty = s_q.duty;
    assign act_hi   = s_q.act_hi;
    assign idle_hi  = s_q.idle_hi;

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
    parameter int CNT_W = 16
) (
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] act_per,
    input  logic [CNT_W-1:0] act_duty,
    input  logic             act_hi,
    input  logic             idle_hi,
    output logic             pwm_out
);

    logic in_active;

    always_comb begin
        in_active = running && (act_per != '0) && (cnt < act_duty);
        pwm_out   = in_active ? act_hi : idle_hi;
    end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
    import pwm_shadow_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] stg_per, stg_duty;
    logic [CNT_W-1:0] act_per, act_duty;
    logic [CNT_W-1:0] cnt;
    logic             act_hi, idle_hi;
    logic             running, wrap;

    logic unused_ctrl;
    assign unused_ctrl = ^{ctrl.lp_en, ctrl.rsv, ctrl.align};

    assign running = ctrl.en && (ctrl.mode == MODE_CONT);

    pwm_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .live_cnt (cnt),
        .stg_per  (stg_per),
        .stg_duty (stg_duty),
        .ctrl     (ctrl),
        .rdata    (rdata)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .act_per (act_per),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    pwm_commit #(.CNT_W(CNT_W)) u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .running     (running),
        .wrap        (wrap),
        .lock        (ctrl.lock),
        .stg_per     (stg_per),
        .stg_duty    (stg_duty),
        .stg_act_hi  (ctrl.act_hi),
        .stg_idle_hi (ctrl.idle_hi),
        .act_per     (act_per),
        .act_duty    (act_duty),
        .act_hi      (act_hi),
        .idle_hi     (idle_hi)
    );

    pwm_wave #(.CNT_W(CNT_W)) u_wave (
        .running  (running),
        .cnt      (cnt),
        .act_per  (act_per),
        .act_duty (act_duty),
        .act_hi   (act_hi),
        .idle_hi  (idle_hi),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             wrap,
    input logic             lock,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_per,
    input logic [CNT_W-1:0] act_duty,
    input logic             act_hi,
    input logic             idle_hi,
    input logic             pwm_out
);

    // R4: count stays inside the period
    a_r4_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (running && act_per != '0) |-> (cnt < act_per));

    // R4: count steps by one between wraps
    a_r4_cnt_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> (cnt == $past(cnt) + 1'b1));

    // R6: active settings only move on a wrap while running
    a_r6_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(act_per) && $stable(act_duty)
                                && $stable(act_hi) && $stable(idle_hi)));

    // R7: lock freezes the active settings
    a_r7_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(act_per) && $stable(act_duty)
                  && $stable(act_hi) && $stable(idle_hi)));

    // R10: zero period gives the inactive level
    a_r10_zero_period_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (running && act_per == '0) |-> (pwm_out == idle_hi));

    // R11: stopped timer clears the count
    a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (cnt == '0));

endmodule

bind pwm_shadow_timer pwm_shadow_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .wrap     (wrap),
    .lock     (ctrl.lock),
    .cnt      (cnt),
    .act_per  (act_per),
    .act_duty (act_duty),
    .act_hi   (act_hi),
    .idle_hi  (idle_hi),
    .pwm_out  (pwm_out)
);

// File: tb/tb_pwm_shadow_timer.sv
module tb_pwm_shadow_timer;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_fail = 0;

    pwm_shadow_timer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic lvl(int per, int duty, int n, logic ah, logic ih);
        if (per == 0) return ih;
        return ((n % per) < duty) ? ah : ih;
    endfunction

    // tasks start and end just after a falling edge
    task automatic wr(logic [3:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // stop with polarity pol, stage period/duty, start; returns at n=0
    task automatic start(int per, int duty, logic [31:0] pol);
        wr(4'hC, pol);
        wr(4'h4, per);
        wr(4'h8, duty);
        wr(4'hC, pol | 32'h3);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pwm_out", {31'b0, pwm_out}, 32'h0);
        rd(4'h0, d); chk("R1 counter", d, 32'h0);
        rd(4'h4, d); chk("R1 period", d, 32'h0);
        rd(4'h8, d); chk("R1 duty", d, 32'h0);
        rd(4'hC, d); chk("R1 control", d, 32'h8);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, d); chk("R2 control mask", d, 32'h0000_017F);
        wr(4'hC, 32'h8);
        wr(4'h4, 32'hABCD_1234);
        rd(4'h4, d); chk("R2 period width", d, 32'h0000_1234);
        wr(4'h8, 32'hFFFF_0005);
        rd(4'h8, d); chk("R2 duty width", d, 32'h0000_0005);
        @(negedge clk);
        chk("R2 rdata holds", rdata, 32'h0000_0005);
    endtask

    task automatic t_wave(string req, int per, int duty, logic [31:0] pol);
        logic ah = pol[3];
        logic ih = pol[4];
        start(per, duty, pol);
        for (int n = 0; n < 3 * per + 4; n++) begin
            chk(req, {31'b0, pwm_out}, {31'b0, lvl(per, duty, n, ah, ih)});
            @(negedge clk);
        end
    endtask

    task automatic t_midwrite();
        int d;
        start(5, 2, 32'h8);
        for (int n = 0; n < 20; n++) begin
            d = (n < 5) ? 2 : (n < 15) ? 4 : 1;
            chk("R6 mid-period", {31'b0, pwm_out}, {31'b0, lvl(5, d, n, 1'b1, 1'b0)});
            wr_en = 1'b0;
            if (n == 0) begin wr_en = 1'b1; addr = 4'h8; wdata = 4; end
            if (n == 9) begin wr_en = 1'b1; addr = 4'h8; wdata = 1; end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic t_lock();
        logic e;
        start(5, 2, 32'h8);
        for (int n = 0; n < 20; n++) begin
            if (n < 10) e = lvl(5, 2, n, 1'b1, 1'b0);
            else        e = lvl(3, 1, n - 10, 1'b0, 1'b1);
            chk((n < 10) ? "R7 locked hold" : "R8 joint commit",
                {31'b0, pwm_out}, {31'b0, e});
            wr_en = 1'b0;
            case (n)
                0: begin wr_en = 1'b1; addr = 4'hC; wdata = 32'h4B; end
                1: begin wr_en = 1'b1; addr = 4'h4; wdata = 3; end
                2: begin wr_en = 1'b1; addr = 4'h8; wdata = 1; end
                8: begin wr_en = 1'b1; addr = 4'hC; wdata = 32'h13; end
                default: ;
            endcase
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic t_counter();
        start(10, 3, 32'h8);
        for (int n = 0; n < 9; n++) begin
            chk("R4 out during reads", {31'b0, pwm_out}, {31'b0, lvl(10, 3, n, 1'b1, 1'b0)});
            if (n == 3) chk("R3 live count", rdata, 32'd2);
            if (n == 7) chk("R3 write ignored", rdata, 32'd6);
            wr_en = 1'b0; rd_en = 1'b0;
            if (n == 2 || n == 6) begin rd_en = 1'b1; addr = 4'h0; end
            if (n == 4) begin wr_en = 1'b1; addr = 4'h0; wdata = 32'h55; end
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic t_stop();
        logic e;
        start(6, 2, 32'h8);
        for (int n = 0; n < 10; n++) begin
            if (n < 4)       e = lvl(6, 2, n, 1'b1, 1'b0);
            else if (n == 4) e = 1'b0;
            else             e = 1'b1;
            chk("R11 stop level", {31'b0, pwm_out}, {31'b0, e});
            if (n == 7) chk("R11 count cleared", rdata, 32'd0);
            wr_en = 1'b0; rd_en = 1'b0;
            if (n == 3) begin wr_en = 1'b1; addr = 4'hC; wdata = 32'h10; end
            if (n == 6) begin rd_en = 1'b1; addr = 4'h0; end
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_wave("R4 per5 duty2", 5, 2, 32'h8);
        t_wave("R4 per7 duty3", 7, 3, 32'h8);
        t_wave("R5 inverted", 5, 2, 32'h10);
        t_wave("R5 both high", 4, 1, 32'h18);
        t_wave("R9 duty eq period", 4, 4, 32'h8);
        t_wave("R9 duty over period", 3, 9, 32'h8);
        t_wave("R10 zero period", 0, 3, 32'h8);
        t_wave("R10 zero period inverted", 0, 3, 32'h10);
        t_midwrite();
        t_lock();
        t_counter();
        t_stop();
        summary();
        $finish;
    end

endmodule